// File: doc/BRIEF.md
# Pad configuration register bank with commit protection

This block stores the pad configuration of one GPIO port of eight pins: which pins hand control to a peripheral (alternate function), which have their digital input buffer enabled, and which have a weak pull-up or pull-down selected. Software reaches the six registers over a single-cycle register bus with an address, write data, a write strobe and read data. The stored values drive the per-pin configuration outputs straight to the pads.

Some pins carry critical functions, such as a non-maskable interrupt input or a debug interface. A parameter mask marks these pins as protected. A protected bit of the four configuration registers changes only when two conditions hold: the port has been unlocked by writing a key to the lock register, and the matching bit of the commit register is 1. Pull-up and pull-down select are kept mutually exclusive per pin. Reset values are set by parameters, so a group of pins can come out of reset already handed to a peripheral, with pull-ups on where that group needs them.

Top module: `gpcfg_bank`

## Requirements
- R1: After reset, alternate-function and digital-enable hold `AFDEN_RST_MASK`, pull-up holds `PUP_RST_MASK`, pull-down is 0, the lock register reads 1 and the commit register holds the inverse of `PROT_MASK`.
- R2: A write to a pin outside `PROT_MASK` in the alternate-function, digital-enable, pull-up or pull-down register takes effect at the next clock edge, whatever the lock state, and appears on the matching pad output.
- R3: A write to a protected bit leaves that bit unchanged when the port is locked or when the matching commit bit is 0.
- R4: A write to a protected bit takes effect when the port is unlocked and the matching commit bit is 1.
- R5: A pin never has pull-up and pull-down selected together. A 1 written and accepted in pull-up clears that pin's pull-down, and a 1 accepted in pull-down clears that pin's pull-up.
- R6: Writing 32'hC0DE5A17 to the lock register unlocks the port and writing any other value locks it. The lock register reads 1 while locked and 0 while unlocked, in bit 0.
- R7: The commit register takes a write only while the port is unlocked. A write while locked leaves it unchanged.
- R8: In every register, read data bits [31:8] are 0 and write data bits [31:8] have no effect.
- R9: A read of an offset that maps to no register returns 0, and a write to such an offset changes no register.
- R10: Read data reflects the stored value in the same cycle the address is presented.
- R11: Register offsets: alternate-function 0x420, pull-up 0x510, pull-down 0x514, digital-enable 0x51C, lock 0x520, commit 0x524. Bit n of each configuration register belongs to pin n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_altf | output | NPINS | Alternate-function select per pin |
| pad_den | output | NPINS | Digital enable per pin |
| pad_pup | output | NPINS | Pull-up select per pin |
| pad_pdn | output | NPINS | Pull-down select per pin |

## Verification
On a single pull-up or pull-down write, the commit gate and the pull exclusivity rule act together. The gate decides bit by bit whether the write lands, and the exclusivity rule clears the opposite pull for every bit that lands. The bench provokes this with writes whose data covers protected and unprotected pins at once, under the locked state, under the unlocked state with a partial commit mask, and in a long run of random writes. It judges each case by reading back both pull registers and the pad outputs against a model that applies the gate first and the clearing only to the bits that pass.

// File: rtl/gpcfg_pkg.sv
package gpcfg_pkg;

    localparam int unsigned BUS_AW = 12;
    localparam int unsigned BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFS_ALTF = 12'h420;
    localparam logic [BUS_AW-1:0] OFS_PUP  = 12'h510;
    localparam logic [BUS_AW-1:0] OFS_PDN  = 12'h514;
    localparam logic [BUS_AW-1:0] OFS_DEN  = 12'h51C;
    localparam logic [BUS_AW-1:0] OFS_LOCK = 12'h520;
    localparam logic [BUS_AW-1:0] OFS_CMT  = 12'h524;

    localparam logic [BUS_DW-1:0] UNLOCK_KEY = 32'hC0DE5A17;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ALTF,
        SEL_PUP,
        SEL_PDN,
        SEL_DEN,
        SEL_LOCK,
        SEL_CMT
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [BUS_DW-1:0] data;
    } bus_req_t;

    function automatic reg_sel_e decode_ofs(input logic [BUS_AW-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_ALTF: s = SEL_ALTF;
            OFS_PUP:  s = SEL_PUP;
            OFS_PDN:  s = SEL_PDN;
            OFS_DEN:  s = SEL_DEN;
            OFS_LOCK: s = SEL_LOCK;
            OFS_CMT:  s = SEL_CMT;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic is_pad_reg(input reg_sel_e s);
        return (s == SEL_ALTF) || (s == SEL_PUP) || (s == SEL_PDN) || (s == SEL_DEN);
    endfunction

endpackage

// File: rtl/gpcfg_key_gate.sv
module gpcfg_key_gate
    import gpcfg_pkg::*;
#(
    parameter int unsigned      NPINS     = 8,
    parameter logic [NPINS-1:0] PROT_MASK = 8'h0F
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    output logic             unlocked,
    output logic [NPINS-1:0] commit,
    output logic [NPINS-1:0] wr_allow
);

    localparam logic [NPINS-1:0] CMT_RST = ~PROT_MASK;

    logic             unlocked_q;
    logic [NPINS-1:0] commit_q;
    logic             lock_wr;
    logic             cmt_wr;

    assign lock_wr = req.wr && (req.sel == SEL_LOCK);
    assign cmt_wr  = req.wr && (req.sel == SEL_CMT) && unlocked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked_q <= 1'b0;
        end else if (lock_wr) begin
            unlocked_q <= (req.data == UNLOCK_KEY);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_q <= CMT_RST;
        end else if (cmt_wr) begin
            commit_q <= req.data[NPINS-1:0];
        end
    end

    // Per-pin gate: unprotected pins always pass, protected pins need key and commit.
    for (genvar i = 0; i < NPINS; i++) begin : g_allow
        if (PROT_MASK[i]) begin : g_prot
            assign wr_allow[i] = unlocked_q & commit_q[i];
        end else begin : g_free
            assign wr_allow[i] = 1'b1;
        end
    end

    assign unlocked = unlocked_q;
    assign commit   = commit_q;

    p_key_unlocks_r6: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_LOCK && req.data == UNLOCK_KEY) |=> unlocked);

    p_bad_key_locks_r6: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_LOCK && req.data != UNLOCK_KEY) |=> !unlocked);

    p_commit_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(commit));

    p_commit_takes_r7: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_CMT && unlocked) |=> commit == $past(req.data[NPINS-1:0]));

endmodule

// File: rtl/gpcfg_pad_regs.sv
module gpcfg_pad_regs
    import gpcfg_pkg::*;
#(
    parameter int unsigned      NPINS          = 8,
    parameter logic [NPINS-1:0] AFDEN_RST_MASK = 8'h0F,
    parameter logic [NPINS-1:0] PUP_RST_MASK   = 8'h0F
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [NPINS-1:0] wr_allow,
    output logic [NPINS-1:0] altf,
    output logic [NPINS-1:0] den,
    output logic [NPINS-1:0] pup,
    output logic [NPINS-1:0] pdn
);

    logic cfg_wr;
    assign cfg_wr = req.wr && is_pad_reg(req.sel);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic altf_b, den_b, pup_b, pdn_b;
        logic take;
        logic d;

        assign take = cfg_wr && wr_allow[i];
        assign d    = req.data[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                altf_b <= AFDEN_RST_MASK[i];
                den_b  <= AFDEN_RST_MASK[i];
                pup_b  <= PUP_RST_MASK[i];
                pdn_b  <= 1'b0;
            end else if (take) begin
                case (req.sel)
                    SEL_ALTF: altf_b <= d;
                    SEL_DEN:  den_b  <= d;
                    SEL_PUP: begin
                        pup_b <= d;
                        if (d) pdn_b <= 1'b0;
                    end
                    SEL_PDN: begin
                        pdn_b <= d;
                        if (d) pup_b <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end

        assign altf[i] = altf_b;
        assign den[i]  = den_b;
        assign pup[i]  = pup_b;
        assign pdn[i]  = pdn_b;
    end

    p_pull_excl_r5: assert property (@(posedge clk) disable iff (rst)
        (pup & pdn) == '0);

    p_pup_clears_pdn_r5: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_PUP) |=> (pdn & $past(req.data[NPINS-1:0] & wr_allow)) == '0);

    p_blocked_hold_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((((altf ^ $past(altf)) | (den ^ $past(den)) |
                    (pup ^ $past(pup)) | (pdn ^ $past(pdn))) & ~$past(wr_allow)) == '0));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && is_pad_reg(req.sel)) |=>
            ($stable(altf) && $stable(den) && $stable(pup) && $stable(pdn)));

endmodule

// File: rtl/gpcfg_rd_mux.sv
module gpcfg_rd_mux
    import gpcfg_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  reg_sel_e          sel,
    input  logic [NPINS-1:0]  altf,
    input  logic [NPINS-1:0]  den,
    input  logic [NPINS-1:0]  pup,
    input  logic [NPINS-1:0]  pdn,
    input  logic              unlocked,
    input  logic [NPINS-1:0]  commit,
    output logic [BUS_DW-1:0] rdata
);

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_ALTF: rdata[NPINS-1:0] = altf;
            SEL_DEN:  rdata[NPINS-1:0] = den;
            SEL_PUP:  rdata[NPINS-1:0] = pup;
            SEL_PDN:  rdata[NPINS-1:0] = pdn;
            SEL_LOCK: rdata[0]         = ~unlocked;
            SEL_CMT:  rdata[NPINS-1:0] = commit;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpcfg_bank.sv
module gpcfg_bank
    import gpcfg_pkg::*;
#(
    parameter int unsigned      NPINS          = 8,
    parameter logic [NPINS-1:0] PROT_MASK      = 8'h0F,
    parameter logic [NPINS-1:0] AFDEN_RST_MASK = 8'h0F,
    parameter logic [NPINS-1:0] PUP_RST_MASK   = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_wen,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic [NPINS-1:0]  pad_altf,
    output logic [NPINS-1:0]  pad_den,
    output logic [NPINS-1:0]  pad_pup,
    output logic [NPINS-1:0]  pad_pdn
);

    bus_req_t         req;
    logic             unlocked;
    logic [NPINS-1:0] commit;
    logic [NPINS-1:0] wr_allow;

    assign req.wr   = bus_wen;
    assign req.sel  = decode_ofs(bus_addr);
    assign req.data = bus_wdata;

    gpcfg_key_gate #(
        .NPINS     (NPINS),
        .PROT_MASK (PROT_MASK)
    ) u_gate (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .unlocked (unlocked),
        .commit   (commit),
        .wr_allow (wr_allow)
    );

    gpcfg_pad_regs #(
        .NPINS          (NPINS),
        .AFDEN_RST_MASK (AFDEN_RST_MASK),
        .PUP_RST_MASK   (PUP_RST_MASK)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .wr_allow (wr_allow),
        .altf     (pad_altf),
        .den      (pad_den),
        .pup      (pad_pup),
        .pdn      (pad_pdn)
    );

    gpcfg_rd_mux #(
        .NPINS (NPINS)
    ) u_rd (
        .sel      (req.sel),
        .altf     (pad_altf),
        .den      (pad_den),
        .pup      (pad_pup),
        .pdn      (pad_pdn),
        .unlocked (unlocked),
        .commit   (commit),
        .rdata    (bus_rdata)
    );

    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[BUS_DW-1:NPINS] == '0);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (req.sel == SEL_NONE) |-> bus_rdata == '0);

    p_locked_prot_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> ((pad_altf ^ $past(pad_altf)) & PROT_MASK) == '0);

endmodule

// File: tb/gpcfg_bank_tb.sv
`timescale 1ns/1ps
module gpcfg_bank_tb;
    import gpcfg_pkg::*;

    localparam logic [7:0] PROT  = 8'h0F;
    localparam logic [7:0] AFRST = 8'h0F;
    localparam logic [7:0] PURST = 8'h0F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_altf, pad_den, pad_pup, pad_pdn;

    always #2.5 clk = ~clk;

    gpcfg_bank u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wen(bus_wen), .bus_rdata(bus_rdata), .pad_altf(pad_altf),
        .pad_den(pad_den), .pad_pup(pad_pup), .pad_pdn(pad_pdn)
    );

    typedef struct {
        bit          is_pad;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Model built from the requirements
    logic [7:0] m_af, m_den, m_pu, m_pd, m_cmt;
    bit         m_unl;

    function automatic void m_reset();
        m_af = AFRST; m_den = AFRST; m_pu = PURST; m_pd = 8'h00;
        m_cmt = ~PROT; m_unl = 0;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h420: return {24'h0, m_af};
            12'h51C: return {24'h0, m_den};
            12'h510: return {24'h0, m_pu};
            12'h514: return {24'h0, m_pd};
            12'h520: return {31'h0, ~m_unl};
            12'h524: return {24'h0, m_cmt};
            default: return 32'h0;
        endcase
    endfunction

    function automatic void m_write(input logic [11:0] a, input logic [31:0] d);
        logic [7:0] ok;
        logic [7:0] dd;
        dd = d[7:0];
        ok = ~PROT | (m_unl ? m_cmt : 8'h00);
        case (a)
            12'h420: m_af  = (m_af  & ~ok) | (dd & ok);
            12'h51C: m_den = (m_den & ~ok) | (dd & ok);
            12'h510: begin m_pu = (m_pu & ~ok) | (dd & ok); m_pd = m_pd & ~(dd & ok); end
            12'h514: begin m_pd = (m_pd & ~ok) | (dd & ok); m_pu = m_pu & ~(dd & ok); end
            12'h520: m_unl = (d == 32'hC0DE5A17);
            12'h524: if (m_unl) m_cmt = dd;
            default: ;
        endcase
    endfunction

    // Driver
    task automatic op(input bit w, input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wen = w; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        op(1, a, d);
        m_write(a, d);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        item_t it;
        op(0, a, 32'h0);
        it.is_pad = 0; it.exp = m_read(a); it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic pads(input string tag);
        item_t it;
        op(0, 12'h000, 32'h0);
        it.is_pad = 1; it.exp = {m_af, m_den, m_pu, m_pd}; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic rd_all(input string tag);
        rd(12'h420, tag); rd(12'h51C, tag); rd(12'h510, tag);
        rd(12'h514, tag); rd(12'h520, tag); rd(12'h524, tag);
    endtask

    // Monitor: compares in the cycle the read is presented (R10)
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sbq.pop_front();
            act = it.is_pad ? {pad_altf, pad_den, pad_pup, pad_pdn} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, bus_addr, act, it.exp);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state, R11 offsets, R10 same-cycle reads
        rd_all("R1 R11 R10 reset");
        pads("R1 reset pads");

        // R2 unprotected writes while locked; R3 protected bits hold
        wr(12'h420, 32'h0000_00F0);
        rd(12'h420, "R2 R3 altf upper set");
        wr(12'h420, 32'h0000_0000);
        rd(12'h420, "R3 locked protected kept");
        wr(12'h510, 32'h0000_00F0);
        rd(12'h510, "R2 pup write");
        // R5 pull-down write clears pull-up on pins 4,5
        wr(12'h514, 32'h0000_0030);
        rd(12'h514, "R5 pdn set");
        rd(12'h510, "R5 pup cleared");
        pads("R2 R5 pads");

        // R7 commit frozen while locked
        wr(12'h524, 32'h0000_00FF);
        rd(12'h524, "R7 commit locked");

        // R6 wrong key keeps locked, right key unlocks
        wr(12'h520, 32'h1234_5678);
        rd(12'h520, "R6 bad key");
        wr(12'h520, 32'hC0DE_5A17);
        rd(12'h520, "R6 key unlocks");

        // R3 unlocked but commit bit clear
        wr(12'h420, 32'h0000_0000);
        rd(12'h420, "R3 commit clear blocks");

        // R7 commit writable when unlocked, R4 then protected bits move
        wr(12'h524, 32'h0000_0005);
        rd(12'h524, "R7 commit unlocked");
        wr(12'h420, 32'h0000_0000);
        rd(12'h420, "R4 protected cleared");
        wr(12'h514, 32'h0000_000F);
        rd(12'h514, "R4 R5 pdn partial");
        rd(12'h510, "R5 pup partial clear");
        pads("R4 R5 pads");

        // R6 relock, R3 again
        wr(12'h520, 32'h0000_0000);
        rd(12'h520, "R6 relock");
        wr(12'h420, 32'h0000_00FF);
        rd(12'h420, "R3 relocked");

        // R8 reserved bits
        wr(12'h51C, 32'hFFFF_FF00);
        rd(12'h51C, "R8 rsvd write");
        wr(12'h51C, 32'hABCD_12F0);
        rd(12'h51C, "R8 rsvd ignored");

        // R9 unmapped offsets
        wr(12'h528, 32'hFFFF_FFFF);
        rd(12'h528, "R9 unmapped read");
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, "R9 unmapped zero");
        rd_all("R9 nothing changed");
        pads("R9 pads");

        // Random mixes: R2 R3 R4 R5 R7 gate and pull rules together
        for (int k = 0; k < 400; k++) begin
            logic [11:0] a;
            logic [31:0] d;
            int s;
            s = $urandom_range(0, 6);
            case (s)
                0: a = 12'h420; 1: a = 12'h51C; 2: a = 12'h510; 3: a = 12'h514;
                4: a = 12'h520; 5: a = 12'h524; default: a = 12'h528;
            endcase
            d = $urandom();
            if (s == 4 && d[0]) d = 32'hC0DE_5A17;
            wr(a, d);
            rd(12'h510, "R5 rand pup");
            rd(12'h514, "R5 rand pdn");
            if (k % 8 == 0) begin
                rd_all("R3 R4 R7 rand");
                pads("R2 rand pads");
            end
        end

        op(0, 12'h000, 32'h0);
        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule